// File: doc/BRIEF.md
# Chained DMA Channel Address Engine

This block is the address and sequencing half of one DMA channel. It produces the memory address of each element of a transfer and offers it on a request/acknowledge handshake. Only the channel's own progress is modelled here. Bus arbitration, the data path and the peripheral side belong to the neighbouring logic. Two instances, one walking the source buffer and one walking the destination buffer, together make a memory-to-memory copy.

A transfer is set up in one of two ways. Software can write the setup registers and then set a start bit. Software can also point the channel at a parameter descriptor in memory, which the channel reads through a word-wide fetch port. The address moves by a signed stride, which may be negative, zero or positive. A transfer ends in one of three ways, chosen by a flow field:

- **Stop:** the channel goes idle.
- **Circular:** the working address and count are reloaded from the setup registers and the channel carries on.
- **Chain:** the channel fetches the descriptor that the current one points to.

A sticky pass interrupt and a sticky setup-error flag report events. Both are cleared by write-one-to-clear.

Top module: `chan_addr_engine`

## Requirements
- R1: After reset the channel is idle: `busy`, `el_req`, `desc_req`, `pass_irq` and `cfg_err` are all low.
- R2: The registers, by write offset, are:
  - 0: start address.
  - 1: element count, in the low bits.
  - 2: signed stride, in the low bits.
  - 3: config, with bits [1:0] the flow (0 stop, 1 circular, 2 chain, 3 treated as stop) and bit 2 the interrupt enable.
  - 4: descriptor pointer.
  - 5: control.
  - 6: status clear.

  Writing control bit 0 while idle with a non-zero count makes `busy` and `el_req` high on the next cycle, with `el_addr` equal to the start address.
- R3: The address advances by the sign-extended stride, and the count drops by one, only in a cycle where `el_req` and `el_ack` are both high. While `el_ack` is low, `el_req` stays high and `el_addr` holds.
- R4: With flow 0, the channel goes idle (`busy` low) right after the count-th element is accepted.
- R5: With flow 1, at the end of each pass the address and count reload from the setup values and elements continue without a pause. Writes to offsets 0–4 while busy are ignored.
- R6: At the end of each pass, `pass_irq` is set if config bit 2 is set. Writing offset 6 with bit 0 set clears it. When a set and a clear fall in the same cycle, the set wins.
- R7: Writing control bit 1 (with bit 0 clear) while idle fetches five words, in this order: next pointer, start address, count, stride, config. They are read from the descriptor pointer plus 0, 4, 8, 12 and 16. `desc_req` is held until each word is acknowledged. After the fifth word the transfer starts.
- R8: With flow 2, at the end of a pass the channel fetches the descriptor at the current next pointer and runs it. The chain ends when a descriptor's flow is 0.
- R9: A start with a count of zero, from either a register start or a fetched descriptor, sets `cfg_err`, issues no element and leaves the channel idle. Writing offset 6 with bit 1 set clears `cfg_err`.
- R10: `el_last` is high exactly while the offered element is the last one of the current pass.
- R11: Writes to control while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| desc_req | output | 1 | Descriptor word read request |
| desc_addr | output | 32 | Descriptor word byte address |
| desc_ack | input | 1 | Descriptor word returned this cycle |
| desc_rdata | input | 32 | Descriptor word data |
| el_req | output | 1 | Element transfer request |
| el_addr | output | 32 | Element address |
| el_ack | input | 1 | Element accepted |
| el_last | output | 1 | Offered element ends the pass |
| busy | output | 1 | Channel active |
| pass_irq | output | 1 | Sticky pass-complete interrupt |
| cfg_err | output | 1 | Sticky zero-count error |

## Verification
The interesting collision is the end of a circular pass coinciding with a software write-one-to-clear of the pass interrupt. The bench holds `el_ack` high, waits until `el_last` shows the final element, and issues the clear write in that same cycle. It then expects `pass_irq` to remain set. A second clear, issued in a cycle where `el_last` is low, must drop the flag, which shows that the surviving bit came from the priority rule and not from a clear that was lost.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   typedef enum logic [1:0] {
      FLOW_STOP  = 2'd0,
      FLOW_CIRC  = 2'd1,
      FLOW_CHAIN = 2'd2
   } flow_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_RUN   = 2'd2
   } ctl_state_e;

   // register write offsets
   localparam int unsigned REG_BASE   = 0;
   localparam int unsigned REG_LEN    = 1;
   localparam int unsigned REG_STRIDE = 2;
   localparam int unsigned REG_CFG    = 3;
   localparam int unsigned REG_NEXT   = 4;
   localparam int unsigned REG_CTRL   = 5;
   localparam int unsigned REG_CLR    = 6;

   // descriptor word order in memory
   localparam int unsigned DESC_NEXT   = 0;
   localparam int unsigned DESC_BASE   = 1;
   localparam int unsigned DESC_LEN    = 2;
   localparam int unsigned DESC_STRIDE = 3;
   localparam int unsigned DESC_CFG    = 4;
   localparam int unsigned DESC_WORDS  = 5;

   // status bit positions
   localparam int unsigned STS_PASS = 0;
   localparam int unsigned STS_ERR  = 1;
   localparam int unsigned STS_BITS = 2;

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
   import dma_eng_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ptr,
   input  logic          desc_ack,
   output logic          desc_req,
   output logic [AW-1:0] desc_addr,
   output logic          word_vld,
   output logic [2:0]    word_idx,
   output logic          done
);
   localparam int unsigned BYTES = DW / 8;
   localparam int unsigned BSH   = $clog2(BYTES);
   localparam logic [2:0]  LAST  = 3'(DESC_WORDS - 1);

   if (DESC_WORDS > 8) begin : g_bad_words
      $error("descriptor word index does not fit");
   end

   logic          active;
   logic [2:0]    idx;
   logic [AW-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         base   <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         base   <= ptr;
      end else if (active && desc_ack) begin
         if (idx == LAST) active <= 1'b0;
         idx <= idx + 3'd1;
      end
   end

   assign desc_req  = active;
   assign desc_addr = base + (AW'(idx) << BSH);
   assign word_vld  = active && desc_ack;
   assign word_idx  = idx;
   assign done      = word_vld && (idx == LAST);

endmodule

// File: rtl/dma_addr_walk.sv
module dma_addr_walk #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16,
   parameter int unsigned SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] len,
   input  logic [SW-1:0] stride,
   input  logic          accept,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] cnt,
   output logic [AW-1:0] step,
   output logic          last
);
   if (SW > AW) begin : g_bad_sw
      $error("stride wider than address");
   end

   // sign extension variant picked by the stride width
   if (SW < AW) begin : g_ext
      assign step = {{(AW-SW){stride[SW-1]}}, stride};
   end else begin : g_full
      assign step = stride[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else if (load) begin
         addr <= base;
         cnt  <= len;
      end else if (accept) begin
         addr <= addr + step;
         cnt  <= cnt - CW'(1);
      end
   end

   assign last = (cnt == CW'(1));

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_eng_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STS_BITS-1:0] set,
   input  logic [STS_BITS-1:0] clr,
   output logic [STS_BITS-1:0] sts
);
   for (genvar i = 0; i < STS_BITS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sts[i] <= 1'b0;
         else if (set[i]) sts[i] <= 1'b1;
         else if (clr[i]) sts[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/chan_addr_engine.sv
module chan_addr_engine
   import dma_eng_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter int unsigned CW = 16,
   parameter int unsigned SW = 16,
   parameter int unsigned RA = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [RA-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic          desc_req,
   output logic [AW-1:0] desc_addr,
   input  logic          desc_ack,
   input  logic [DW-1:0] desc_rdata,
   output logic          el_req,
   output logic [AW-1:0] el_addr,
   input  logic          el_ack,
   output logic          el_last,
   output logic          busy,
   output logic          pass_irq,
   output logic          cfg_err
);
   if (AW > DW || CW > DW || SW > DW) begin : g_bad_width
      $error("setup fields must fit a data word");
   end
   if (RA < 3) begin : g_bad_ra
      $error("register offset needs three bits");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("data width must be whole bytes");
   end

   ctl_state_e state, state_d;

   logic [AW-1:0] base_r, next_r;
   logic [CW-1:0] len_r;
   logic [SW-1:0] stride_r;
   logic [1:0]    flow_r;
   logic          ien_r;

   logic          f_word_vld, f_done;
   logic [2:0]    f_idx;
   logic [CW-1:0] w_cnt;
   logic [AW-1:0] w_step;
   logic          w_last;

   logic wr_ctrl, go_reg, go_desc, zero_len, accept, pass_end;
   logic flow_circ, flow_chain, fetch_start, walk_load, err_set, irq_set;
   logic clr_wr;
   logic [STS_BITS-1:0] sts_set, sts_clr, sts;

   assign wr_ctrl    = reg_we && (reg_addr == RA'(REG_CTRL)) && (state == ST_IDLE);
   assign go_reg     = wr_ctrl && reg_wdata[0];
   assign go_desc    = wr_ctrl && !reg_wdata[0] && reg_wdata[1];
   assign zero_len   = (len_r == '0);
   assign accept     = (state == ST_RUN) && el_ack;
   assign pass_end   = accept && w_last;
   assign flow_circ  = (flow_r == FLOW_CIRC);
   assign flow_chain = (flow_r == FLOW_CHAIN);

   assign fetch_start = go_desc || (pass_end && flow_chain);
   assign walk_load   = ((go_reg || f_done) && !zero_len) || (pass_end && flow_circ);
   assign err_set     = (go_reg || f_done) && zero_len;
   assign irq_set     = pass_end && ien_r;

   // setup registers: software while idle, descriptor words while fetching
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_r   <= '0;
         next_r   <= '0;
         len_r    <= '0;
         stride_r <= '0;
         flow_r   <= '0;
         ien_r    <= 1'b0;
      end else if (state == ST_IDLE && reg_we) begin
         case (reg_addr)
            RA'(REG_BASE):   base_r   <= reg_wdata[AW-1:0];
            RA'(REG_LEN):    len_r    <= reg_wdata[CW-1:0];
            RA'(REG_STRIDE): stride_r <= reg_wdata[SW-1:0];
            RA'(REG_CFG): begin
               flow_r <= reg_wdata[1:0];
               ien_r  <= reg_wdata[2];
            end
            RA'(REG_NEXT):   next_r   <= reg_wdata[AW-1:0];
            default: ;
         endcase
      end else if (f_word_vld) begin
         case (f_idx)
            3'(DESC_NEXT):   next_r   <= desc_rdata[AW-1:0];
            3'(DESC_BASE):   base_r   <= desc_rdata[AW-1:0];
            3'(DESC_LEN):    len_r    <= desc_rdata[CW-1:0];
            3'(DESC_STRIDE): stride_r <= desc_rdata[SW-1:0];
            3'(DESC_CFG): begin
               flow_r <= desc_rdata[1:0];
               ien_r  <= desc_rdata[2];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      state_d = state;
      case (state)
         ST_IDLE: begin
            if (go_reg && !zero_len) state_d = ST_RUN;
            else if (go_desc)        state_d = ST_FETCH;
         end
         ST_FETCH: begin
            if (f_done) state_d = zero_len ? ST_IDLE : ST_RUN;
         end
         ST_RUN: begin
            if (pass_end) begin
               if (flow_circ)       state_d = ST_RUN;
               else if (flow_chain) state_d = ST_FETCH;
               else                 state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end

   dma_desc_fetch #(.AW(AW), .DW(DW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (fetch_start),
      .ptr       (next_r),
      .desc_ack  (desc_ack),
      .desc_req  (desc_req),
      .desc_addr (desc_addr),
      .word_vld  (f_word_vld),
      .word_idx  (f_idx),
      .done      (f_done)
   );

   dma_addr_walk #(.AW(AW), .CW(CW), .SW(SW)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (walk_load),
      .base   (base_r),
      .len    (len_r),
      .stride (stride_r),
      .accept (accept),
      .addr   (el_addr),
      .cnt    (w_cnt),
      .step   (w_step),
      .last   (w_last)
   );

   assign clr_wr  = reg_we && (reg_addr == RA'(REG_CLR));
   assign sts_set = {err_set, irq_set};
   assign sts_clr = {clr_wr && reg_wdata[STS_ERR], clr_wr && reg_wdata[STS_PASS]};

   dma_irq_status u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sts_set),
      .clr   (sts_clr),
      .sts   (sts)
   );

   assign el_req   = (state == ST_RUN);
   assign el_last  = el_req && w_last;
   assign busy     = (state != ST_IDLE);
   assign pass_irq = sts[STS_PASS];
   assign cfg_err  = sts[STS_ERR];

endmodule

// File: rtl/chan_addr_engine_chk.sv
module chan_addr_engine_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   parameter int unsigned RA = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [RA-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          desc_req,
   input logic          el_req,
   input logic [AW-1:0] el_addr,
   input logic          el_ack,
   input logic          el_last,
   input logic          busy,
   input logic          pass_irq,
   input logic          cfg_err,
   input logic [AW-1:0] step
);
   logic clr_pass, clr_err;
   assign clr_pass = reg_we && (reg_addr == RA'(6)) && reg_wdata[0];
   assign clr_err  = reg_we && (reg_addr == RA'(6)) && reg_wdata[1];

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      el_req && el_ack && !el_last |=> el_addr == $past(el_addr) + $past(step));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      el_req && !el_ack |=> el_req && $stable(el_addr));

   // R2
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (el_req || desc_req) |-> busy);

   // R7
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(el_req && desc_req));

   // R6
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_irq && !clr_pass |=> pass_irq);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err && !clr_err |=> cfg_err);

   // R10
   last_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      el_last |-> el_req);

endmodule

bind chan_addr_engine chan_addr_engine_chk #(.AW(AW), .DW(DW), .RA(RA)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .desc_req  (desc_req),
   .el_req    (el_req),
   .el_addr   (el_addr),
   .el_ack    (el_ack),
   .el_last   (el_last),
   .busy      (busy),
   .pass_irq  (pass_irq),
   .cfg_err   (cfg_err),
   .step      (w_step)
);

// File: tb/chan_addr_engine_bench.sv
module chan_addr_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        desc_req, el_req, el_last, busy, pass_irq, cfg_err;
   logic [31:0] desc_addr, el_addr;
   logic        desc_ack = 1'b0;
   logic [31:0] desc_rdata = '0;
   logic        el_ack = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   chan_addr_engine u_chan_addr_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .desc_req(desc_req), .desc_addr(desc_addr),
      .desc_ack(desc_ack), .desc_rdata(desc_rdata), .el_req(el_req),
      .el_addr(el_addr), .el_ack(el_ack), .el_last(el_last), .busy(busy),
      .pass_irq(pass_irq), .cfg_err(cfg_err)
   );

   int n_run = 0, n_fail = 0, cyc = 0;
   int ack_mode = 0;
   bit done = 0;
   logic [31:0] dmem [int];
   logic [31:0] acc_q[$];
   logic [31:0] dacc_q[$];

   // reference model state
   int          m_state = 0;
   logic [31:0] m_base = 0, m_next = 0, m_addr = 0, m_fptr = 0;
   logic [15:0] m_len = 0, m_stride = 0, m_cnt = 0;
   logic [1:0]  m_flow = 0;
   logic        m_ien = 0, m_irq = 0, m_err = 0;
   int          m_fidx = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin : model
      bit s_irq, s_err;
      cyc++;
      s_irq = 0; s_err = 0;
      if (!rst_n) begin
         m_state = 0; m_base = 0; m_next = 0; m_addr = 0; m_fptr = 0;
         m_len = 0; m_stride = 0; m_cnt = 0; m_flow = 0; m_ien = 0;
         m_irq = 0; m_err = 0; m_fidx = 0;
      end else begin
         case (m_state)
            0: if (reg_we) begin
               case (reg_addr)
                  3'd0: m_base = reg_wdata;
                  3'd1: m_len = reg_wdata[15:0];
                  3'd2: m_stride = reg_wdata[15:0];
                  3'd3: begin m_flow = reg_wdata[1:0]; m_ien = reg_wdata[2]; end
                  3'd4: m_next = reg_wdata;
                  3'd5: if (reg_wdata[0]) begin
                     if (m_len == 0) s_err = 1;
                     else begin m_addr = m_base; m_cnt = m_len; m_state = 2; end
                  end else if (reg_wdata[1]) begin
                     m_fptr = m_next; m_fidx = 0; m_state = 1;
                  end
                  default: ;
               endcase
            end
            1: if (desc_ack) begin
               case (m_fidx)
                  0: m_next = desc_rdata;
                  1: m_base = desc_rdata;
                  2: m_len = desc_rdata[15:0];
                  3: m_stride = desc_rdata[15:0];
                  default: begin m_flow = desc_rdata[1:0]; m_ien = desc_rdata[2]; end
               endcase
               if (m_fidx == 4) begin
                  if (m_len == 0) begin s_err = 1; m_state = 0; end
                  else begin m_addr = m_base; m_cnt = m_len; m_state = 2; end
               end else m_fidx++;
            end
            default: if (el_ack) begin
               if (m_cnt == 1) begin
                  s_irq = m_ien;
                  if (m_flow == 1) begin m_addr = m_base; m_cnt = m_len; end
                  else if (m_flow == 2) begin m_fptr = m_next; m_fidx = 0; m_state = 1; end
                  else m_state = 0;
               end else begin
                  m_addr = m_addr + {{16{m_stride[15]}}, m_stride};
                  m_cnt = m_cnt - 1;
               end
            end
         endcase
         if (reg_we && reg_addr == 3'd6) begin
            if (reg_wdata[0]) m_irq = 0;
            if (reg_wdata[1]) m_err = 0;
         end
         if (s_irq) m_irq = 1;
         if (s_err) m_err = 1;
      end
   end

   // per-cycle comparison, then responders
   always @(negedge clk) begin : cmp
      bit ok;
      if (rst_n && !done) begin
         ok = 1;
         if (busy !== (m_state != 0)) begin ok = 0;
            $display("FAIL R4 busy actual=%b expected=%b", busy, m_state != 0); end
         if (el_req !== (m_state == 2)) begin ok = 0;
            $display("FAIL R2 el_req actual=%b expected=%b", el_req, m_state == 2); end
         if (m_state == 2 && el_addr !== m_addr) begin ok = 0;
            $display("FAIL R3 el_addr actual=%h expected=%h", el_addr, m_addr); end
         if (el_last !== (m_state == 2 && m_cnt == 1)) begin ok = 0;
            $display("FAIL R10 el_last actual=%b expected=%b", el_last, m_state == 2 && m_cnt == 1); end
         if (desc_req !== (m_state == 1)) begin ok = 0;
            $display("FAIL R7 desc_req actual=%b expected=%b", desc_req, m_state == 1); end
         if (m_state == 1 && desc_addr !== m_fptr + 32'(m_fidx * 4)) begin ok = 0;
            $display("FAIL R7 desc_addr actual=%h expected=%h", desc_addr, m_fptr + 32'(m_fidx * 4)); end
         if (pass_irq !== m_irq) begin ok = 0;
            $display("FAIL R6 pass_irq actual=%b expected=%b", pass_irq, m_irq); end
         if (cfg_err !== m_err) begin ok = 0;
            $display("FAIL R9 cfg_err actual=%b expected=%b", cfg_err, m_err); end
         n_run++;
         if (!ok) n_fail++;
      end
      el_ack   = el_req && (ack_mode == 0 || (cyc % 3) != 0);
      desc_ack = desc_req && ((cyc % 2) == 0);
      desc_rdata = dmem.exists(int'(desc_addr)) ? dmem[int'(desc_addr)] : 32'h0;
      if (el_req && el_ack) acc_q.push_back(el_addr);
      if (desc_req && desc_ack) dacc_q.push_back(desc_addr);
   end

   // call at a negedge; returns at the next negedge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   initial begin
      dmem[32'h100] = 32'h200;  dmem[32'h104] = 32'h4000; dmem[32'h108] = 32'd2;
      dmem[32'h10C] = 32'd4;    dmem[32'h110] = 32'h6;
      dmem[32'h200] = 32'h0;    dmem[32'h204] = 32'h5000; dmem[32'h208] = 32'd3;
      dmem[32'h20C] = 32'hFFFE; dmem[32'h210] = 32'h0;
      dmem[32'h300] = 32'h0;    dmem[32'h304] = 32'h6000; dmem[32'h308] = 32'd0;
      dmem[32'h30C] = 32'd1;    dmem[32'h310] = 32'h4;

      @(negedge clk);
      do_reset();
      // R1 reset state
      check(!busy && !el_req && !desc_req && !pass_irq && !cfg_err, "R1", "reset outputs",
            {27'd0, busy, el_req, desc_req, pass_irq, cfg_err}, 32'd0);

      // stop flow, positive stride, irregular ack
      ack_mode = 1;
      wr(3'd0, 32'h1000); wr(3'd1, 32'd4); wr(3'd2, 32'd8); wr(3'd3, 32'h4);
      acc_q.delete();
      wr(3'd5, 32'h1);
      check(el_req && el_addr == 32'h1000, "R2", "first element address", el_addr, 32'h1000);
      wait_idle();
      check(!busy, "R4", "idle after stop pass", {31'd0, busy}, 32'd0);
      check(acc_q.size() == 4, "R3", "accepted count", acc_q.size(), 4);
      for (int i = 0; i < 4 && i < acc_q.size(); i++)
         check(acc_q[i] == 32'h1000 + 32'(i * 8), "R3", "accepted address", acc_q[i], 32'h1000 + 32'(i * 8));
      check(pass_irq, "R6", "irq after pass", {31'd0, pass_irq}, 32'd1);
      wr(3'd6, 32'h1);
      check(!pass_irq, "R6", "irq cleared", {31'd0, pass_irq}, 32'd0);

      // zero stride
      wr(3'd0, 32'h3000); wr(3'd1, 32'd3); wr(3'd2, 32'd0); wr(3'd3, 32'h0);
      acc_q.delete();
      wr(3'd5, 32'h1);
      wait_idle();
      check(acc_q.size() == 3, "R3", "zero stride count", acc_q.size(), 3);
      foreach (acc_q[i]) check(acc_q[i] == 32'h3000, "R3", "zero stride address", acc_q[i], 32'h3000);

      // zero count
      wr(3'd1, 32'd0);
      wr(3'd5, 32'h1);
      check(cfg_err && !busy && !el_req, "R9", "zero count error", {30'd0, cfg_err, busy}, 32'd2);
      wr(3'd6, 32'h2);
      check(!cfg_err, "R9", "error cleared", {31'd0, cfg_err}, 32'd0);

      // circular, negative stride, ignored writes, set-versus-clear collision
      ack_mode = 0;
      wr(3'd0, 32'h2000); wr(3'd1, 32'd3); wr(3'd2, 32'hFFFC); wr(3'd3, 32'h5);
      acc_q.delete();
      wr(3'd5, 32'h1);
      wr(3'd0, 32'h9999);          // ignored while busy (R5)
      wr(3'd5, 32'h2);             // ignored while busy (R11)
      for (int i = 0; i < 12; i++) @(negedge clk);
      check(busy && desc_req == 0, "R11", "control write ignored", {31'd0, desc_req}, 32'd0);
      for (int i = 0; i < 9 && i < acc_q.size(); i++)
         check(acc_q[i] == 32'h2000 - 32'((i % 3) * 4), "R5", "circular address", acc_q[i], 32'h2000 - 32'((i % 3) * 4));
      while (!el_last) @(negedge clk);
      wr(3'd6, 32'h1);             // clear in the same cycle as pass end
      check(pass_irq, "R6", "set wins over clear", {31'd0, pass_irq}, 32'd1);
      while (el_last) @(negedge clk);
      wr(3'd6, 32'h1);
      check(!pass_irq, "R6", "plain clear", {31'd0, pass_irq}, 32'd0);
      do_reset();

      // descriptor chain
      ack_mode = 1;
      acc_q.delete(); dacc_q.delete();
      wr(3'd4, 32'h100);
      wr(3'd5, 32'h2);
      check(desc_req && desc_addr == 32'h100, "R7", "fetch begins", desc_addr, 32'h100);
      wait_idle();
      check(dacc_q.size() == 10, "R8", "descriptor words read", dacc_q.size(), 10);
      for (int i = 0; i < 10 && i < dacc_q.size(); i++)
         check(dacc_q[i] == (i < 5 ? 32'h100 : 32'h200) + 32'((i % 5) * 4), "R7", "descriptor word address",
               dacc_q[i], (i < 5 ? 32'h100 : 32'h200) + 32'((i % 5) * 4));
      check(acc_q.size() == 5, "R8", "chained elements", acc_q.size(), 5);
      if (acc_q.size() == 5) begin
         check(acc_q[1] == 32'h4004, "R8", "first descriptor element", acc_q[1], 32'h4004);
         check(acc_q[4] == 32'h4FFC, "R8", "second descriptor element", acc_q[4], 32'h4FFC);
      end
      check(pass_irq && !busy, "R8", "chain end", {30'd0, pass_irq, busy}, 32'd2);

      // descriptor with zero count
      acc_q.delete();
      wr(3'd4, 32'h300);
      wr(3'd5, 32'h2);
      wait_idle();
      check(cfg_err && acc_q.size() == 0, "R9", "descriptor zero count", acc_q.size(), 0);

      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule